// File: doc/BRIEF.md
# Binary Image Pixel Counter

This block counts the set pixels of a square binary image by letting the pixels fall. After a start strobe, every set pixel drops one row per cycle toward the bottom edge, but only into a clear cell. All cells update together. After a fixed number of steps each column holds one solid stack resting on the bottom row.

Each column is then combined by XOR with a copy of itself shifted down by one row. This leaves a single marker on the top pixel of each stack. The markers are sent out one per cycle as address events carrying a row and a column. The height of each stack, the image size minus the marker's row, is added to a running total. That total is the exact number of set pixels in the loaded image.

A controller loads an image through the load port while the block is idle, then pulses start. It collects the events and reads the final count once the done flag rises.

Top module: `pixel_stack_counter`

## Requirements
- R1: After reset, `ev_valid` and `done` are low and `count` is zero.
- R2: A `load` pulse captures `img_in`, with bit index `row*N+col` and row 0 as the top row, only while no count is in progress. A `load` pulse during stacking or readout has no effect on the events or on the count.
- R3: Stacking runs for exactly N-1 cycles. The first event, or `done` for an empty image, becomes visible N clock edges after the edge that samples `start`.
- R4: During a fall step, a set pixel moves down one row only when the cell below it is clear. The number of set pixels never changes, and after N-1 steps every column reads as clear cells above set cells.
- R5: Only the top cell of each stack is kept as a marker. Each column with at least one set pixel yields exactly one event, with `ev_col` = column and `ev_row` = N minus the number of set pixels in that column. Columns with no set pixel yield no event.
- R6: Events are issued in strictly increasing column order on consecutive cycles, with no idle cycle for skipped empty columns.
- R7: `count` equals the number of set pixels in the loaded image, up to N*N for a full image. It is valid when `done` rises.
- R8: `done` rises one cycle after the last event, or with no event at all for an all-zero image. It stays high until the next accepted `start`, and `ev_valid` is low while `done` is high.
- R9: A `start` pulse while stacking or readout is in progress is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `img_in` into the pixel array (idle only) |
| img_in | input | N*N | Binary image, bit `row*N+col`, row 0 at the top |
| start | input | 1 | Begin a fall, extract and readout pass |
| ev_valid | output | 1 | An address event is present this cycle |
| ev_row | output | clog2(N) | Row of the stack-top pixel |
| ev_col | output | clog2(N) | Column of the stack-top pixel |
| count | output | clog2(N*N+1) | Exact number of set pixels |
| done | output | 1 | Count complete, held until the next start |

## Verification
The bench builds the block with its default N of 16. This gives a 256-cell array and a 9-bit count, so a full image reaches the largest count of 256, and a pixel in row 0 must fall the whole N-1 steps. With 16 columns, sparse, dense and alternating-row patterns produce event trains with gaps in their column sets. These show whether empty columns are skipped without idle cycles and whether each stack height is reported exactly.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FALL  = 2'd1,
        PH_EMIT  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/psc_fall_grid.sv
module psc_fall_grid #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [N*N-1:0] img_i,
    input  logic           step_en,
    output logic [N*N-1:0] grid_o
);
    localparam int CELLS = N * N;

    logic [CELLS-1:0] grid_d, grid_q, fall_v;

    // one gravity step: a set cell stays when supported, a clear cell takes the pixel above
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic above_v, below_v;
            if (r == 0) begin : g_top
                assign above_v = 1'b0;
            end else begin : g_top_n
                assign above_v = grid_q[(r-1)*N + c];
            end
            if (r == N-1) begin : g_bot
                assign below_v = 1'b1;
            end else begin : g_bot_n
                assign below_v = grid_q[(r+1)*N + c];
            end
            assign fall_v[r*N + c] = grid_q[r*N + c] ? below_v : above_v;
        end
    end

    always_comb begin
        grid_d = grid_q;
        if (load_en) begin
            grid_d = img_i;
        end else if (step_en) begin
            grid_d = fall_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grid_q <= '0;
        end else begin
            grid_q <= grid_d;
        end
    end

    assign grid_o = grid_q;

    // R4: a fall step neither creates nor destroys pixels
    p_conserve_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> ($countones(grid_q) == $past($countones(grid_q))));
endmodule

// File: rtl/psc_top_finder.sv
module psc_top_finder #(
    parameter int N  = 16,
    parameter int RW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  check_en,
    input  logic [N*N-1:0]        grid_i,
    output logic [N-1:0]          nonempty_o,
    output logic [N-1:0][RW-1:0]  top_row_o
);
    for (genvar c = 0; c < N; c++) begin : g_col
        logic [N-1:0]  col_v;
        logic [N-1:0]  mark_v;
        logic [RW-1:0] row_v;

        for (genvar r = 0; r < N; r++) begin : g_cell
            assign col_v[r] = grid_i[r*N + c];
            // compare with the copy shifted one row down; only the stack top differs
            if (r == 0) begin : g_first
                assign mark_v[r] = col_v[r];
            end else begin : g_rest
                assign mark_v[r] = col_v[r] ^ col_v[r-1];
            end
        end

        always_comb begin
            row_v = '0;
            for (int r = 0; r < N; r++) begin
                if (mark_v[r]) begin
                    row_v = row_v | RW'(r);
                end
            end
        end

        assign nonempty_o[c] = col_v[N-1];
        assign top_row_o[c]  = row_v;

        // R5 (and R4 stacked form): at most one marker per column during readout
        p_stack_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
            check_en |-> $onehot0(mark_v));
    end
endmodule

// File: rtl/psc_pick_low.sv
module psc_pick_low #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W-1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/pixel_stack_counter.sv
module pixel_stack_counter
    import pkc_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [N*N-1:0]               img_in,
    input  logic                         start,
    output logic                         ev_valid,
    output logic [$clog2(N)-1:0]         ev_row,
    output logic [$clog2(N)-1:0]         ev_col,
    output logic [$clog2(N*N+1)-1:0]     count,
    output logic                         done
);
    localparam int RW   = $clog2(N);
    localparam int ITW  = $clog2(N);
    localparam int CNTW = $clog2(N*N+1);
    localparam int LAST = N - 2;

    typedef struct packed {
        phase_e          phase;
        logic [ITW-1:0]  iter;
        logic [N-1:0]    served;
        logic            ev_valid;
        logic [RW-1:0]   ev_row;
        logic [RW-1:0]   ev_col;
        logic [CNTW-1:0] count;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N*N-1:0]       grid_w;
    logic [N-1:0]         nonempty_w;
    logic [N-1:0][RW-1:0] top_row_w;
    logic [N-1:0]         pending_w;
    logic                 pick_any_w;
    logic [RW-1:0]        pick_idx_w;
    logic                 idle_w;
    logic                 load_en_w;
    logic                 step_en_w;
    logic [RW-1:0]        pick_row_w;

    assign idle_w    = (ctl_q.phase == PH_IDLE) || (ctl_q.phase == PH_DONE);
    assign load_en_w = load && idle_w;
    assign step_en_w = (ctl_q.phase == PH_FALL);

    psc_fall_grid #(.N(N)) i_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en_w),
        .img_i   (img_in),
        .step_en (step_en_w),
        .grid_o  (grid_w)
    );

    psc_top_finder #(.N(N), .RW(RW)) i_finder (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_en   (ctl_q.phase == PH_EMIT),
        .grid_i     (grid_w),
        .nonempty_o (nonempty_w),
        .top_row_o  (top_row_w)
    );

    assign pending_w = nonempty_w & ~ctl_q.served;

    psc_pick_low #(.W(N), .IW(RW)) i_pick (
        .req_i (pending_w),
        .any_o (pick_any_w),
        .idx_o (pick_idx_w)
    );

    assign pick_row_w = top_row_w[pick_idx_w];

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.ev_valid = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE, PH_DONE: begin
                if (start) begin
                    ctl_d.phase  = PH_FALL;
                    ctl_d.iter   = '0;
                    ctl_d.served = '0;
                    ctl_d.count  = '0;
                    ctl_d.done   = 1'b0;
                end
            end
            PH_FALL: begin
                if (ctl_q.iter == ITW'(LAST)) begin
                    ctl_d.phase = PH_EMIT;
                end else begin
                    ctl_d.iter = ctl_q.iter + 1'b1;
                end
            end
            PH_EMIT: begin
                if (pick_any_w) begin
                    ctl_d.ev_valid           = 1'b1;
                    ctl_d.ev_col             = pick_idx_w;
                    ctl_d.ev_row             = pick_row_w;
                    ctl_d.served[pick_idx_w] = 1'b1;
                    ctl_d.count = ctl_q.count + (CNTW'(N) - CNTW'(pick_row_w));
                end else begin
                    ctl_d.phase = PH_DONE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, iter: '0, served: '0, ev_valid: 1'b0,
                       ev_row: '0, ev_col: '0, count: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ev_valid = ctl_q.ev_valid;
    assign ev_row   = ctl_q.ev_row;
    assign ev_col   = ctl_q.ev_col;
    assign count    = ctl_q.count;
    assign done     = ctl_q.done;

    // R3: the fall phase never runs past N-1 steps
    p_fall_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_FALL) |-> (ctl_q.iter <= ITW'(LAST)));

    // R6: back-to-back events move strictly to higher columns
    p_col_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && $past(ev_valid)) |-> (ev_col > $past(ev_col)));

    // R7: the count never exceeds the pixel total
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(N*N));

    // R8: no event while done is shown, and done only rises from readout
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ev_valid);
    p_done_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(ctl_q.phase) == PH_EMIT));

    // R2: the captured image is held while a pass is running
    p_load_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_EMIT) |=> $stable(grid_w) || (ctl_q.phase != PH_EMIT));
endmodule

// File: tb/test_pixel_stack_counter.sv
module test_pixel_stack_counter;
    localparam int N    = 16;
    localparam int RW   = $clog2(N);
    localparam int CNTW = $clog2(N*N+1);

    logic                clk = 1'b0;
    logic                rst_n;
    logic                load;
    logic [N*N-1:0]      img_in;
    logic                start;
    logic                ev_valid;
    logic [RW-1:0]       ev_row;
    logic [RW-1:0]       ev_col;
    logic [CNTW-1:0]     count;
    logic                done;

    int vecs = 0;
    int miss = 0;
    int cyc = 0;
    int start_cyc = 0;
    int exp_q[$];
    int ev_idx = 0;
    int exp_count = 0;
    int exp_done_rel = 0;
    bit armed = 1'b0;
    bit done_seen = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pixel_stack_counter #(.N(N)) i_pixel_stack_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .img_in   (img_in),
        .start    (start),
        .ev_valid (ev_valid),
        .ev_row   (ev_row),
        .ev_col   (ev_col),
        .count    (count),
        .done     (done)
    );

    // monitor: pops expected events and checks order, content and timing
    always @(negedge clk) begin
        if (armed) begin
            if (ev_valid) begin
                vecs++;
                if (exp_q.size() == 0) begin
                    miss++;
                    $display("FAIL R5 extra event: got row %0d col %0d expected none", ev_row, ev_col);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (ev_row != RW'(e >> 8) || ev_col != RW'(e & 255)) begin
                        miss++;
                        $display("FAIL R5 event: got row %0d col %0d expected row %0d col %0d",
                                 ev_row, ev_col, e >> 8, e & 255);
                    end
                    if (cyc - start_cyc != N + ev_idx) begin
                        miss++;
                        $display("FAIL R3 R6 event timing: got %0d expected %0d",
                                 cyc - start_cyc, N + ev_idx);
                    end
                end
                ev_idx++;
            end
            if (done && !done_seen) begin
                done_seen = 1'b1;
                vecs++;
                if (cyc - start_cyc != exp_done_rel) begin
                    miss++;
                    $display("FAIL R8 done timing: got %0d expected %0d", cyc - start_cyc, exp_done_rel);
                end
                vecs++;
                if (int'(count) != exp_count) begin
                    miss++;
                    $display("FAIL R7 count: got %0d expected %0d", count, exp_count);
                end
            end
        end
    end

    // driver: loads an image, queues the expected events, runs one pass
    task automatic run_image(input logic [N*N-1:0] img, input bit poke_load, input bit poke_start);
        int n_ev;
        @(negedge clk);
        img_in = img;
        load   = 1'b1;
        @(negedge clk);
        load   = 1'b0;
        exp_q.delete();
        exp_count = 0;
        n_ev = 0;
        for (int c = 0; c < N; c++) begin
            int h;
            h = 0;
            for (int r = 0; r < N; r++) h += int'(img[r*N + c]);
            exp_count += h;
            if (h > 0) begin
                exp_q.push_back(((N - h) << 8) | c);
                n_ev++;
            end
        end
        exp_done_rel = N + n_ev;
        start = 1'b1;
        @(posedge clk);
        #1;
        start_cyc = cyc;
        ev_idx    = 0;
        done_seen = 1'b0;
        armed     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_load) begin
            @(negedge clk);
            img_in = ~img;
            load   = 1'b1;   // R2: must be ignored during the fall phase
            @(negedge clk);
            load   = 1'b0;
        end
        if (poke_start) begin
            wait (ev_idx >= 1);
            @(negedge clk);
            start = 1'b1;    // R9: must be ignored during readout
            @(negedge clk);
            start = 1'b0;
        end
        wait (done_seen);
        repeat (3) @(negedge clk);
        armed = 1'b0;
        vecs++;
        if (exp_q.size() != 0 || ev_idx != n_ev) begin
            miss++;
            $display("FAIL R5 event total: got %0d expected %0d", ev_idx, n_ev);
        end
        vecs++;
        if (done !== 1'b1 || ev_valid !== 1'b0) begin
            miss++;
            $display("FAIL R8 done hold: got done %0b ev_valid %0b expected 1 0", done, ev_valid);
        end
    endtask

    function automatic logic [N*N-1:0] rand_img(input bit sparse);
        logic [N*N-1:0] v;
        for (int k = 0; k < N*N; k += 32) begin
            logic [31:0] w;
            w = $urandom();
            if (sparse) w = w & $urandom() & $urandom();
            for (int b = 0; b < 32; b++) if (k + b < N*N) v[k + b] = w[b];
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        logic [N*N-1:0] img;
        rst_n  = 1'b0;
        load   = 1'b0;
        start  = 1'b0;
        img_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vecs++;
        if (ev_valid !== 1'b0 || done !== 1'b0 || count !== '0) begin
            miss++;
            $display("FAIL R1 reset: got ev_valid %0b done %0b count %0d expected 0 0 0",
                     ev_valid, done, count);
        end

        run_image('0, 1'b0, 1'b0);                            // R8 empty image
        run_image('1, 1'b0, 1'b0);                            // R7 full image, 256
        img = '0; img[0] = 1'b1;
        run_image(img, 1'b0, 1'b0);                           // R4 top pixel falls N-1 rows
        img = '0; img[N*N-1] = 1'b1;
        run_image(img, 1'b0, 1'b0);                           // R5 bottom-right corner
        img = '0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) img[r*N + c] = ((r + c) % 2 == 0);
        run_image(img, 1'b0, 1'b0);                           // R4 checkerboard
        img = '0;
        for (int r = 0; r < N; r += 2)
            for (int c = 0; c < N; c += 3) img[r*N + c] = 1'b1;
        run_image(img, 1'b0, 1'b0);                           // R6 gaps in columns
        img = '0;
        for (int c = 0; c < N; c++) img[c] = 1'b1;
        run_image(img, 1'b0, 1'b0);                           // R3 whole top row
        run_image(rand_img(1'b0), 1'b1, 1'b0);                // R2 load ignored
        run_image(rand_img(1'b0), 1'b0, 1'b1);                // R9 start ignored
        for (int t = 0; t < 4; t++) run_image(rand_img(t[0]), 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule